// File: doc/BRIEF.md
# Double-Buffered Digital Crosspoint

This block routes a set of single-bit data inputs to a set of single-bit data outputs. Each output has its own selector, so any input can drive any number of outputs at the same time. Each selector is steered by a small code held in an active register, and the data path from input to output is purely combinational.

New routing is staged in a shadow bank, one output at a time. The user presents a source code and a destination output number and pulses the load strobe. A separate active-low commit strobe then copies the whole shadow bank into the active bank in a single clock cycle. All strobes are asynchronous to the system clock. Each one passes through a two-flop synchroniser and an edge detector, so the block acts only on the edge that matters.

Reset forces every output to follow input 0 and clears the active bank. It does not touch the shadow bank, so one commit after reset brings back the last routing the user staged.

Top module: `xpt_switch_top`

## Requirements
- R1: Each output `dout[o]` equals `din[s]`, where `s` is the active code of output `o`. Several outputs may hold the same code and then all follow that one input.
- R2: When `load_mode` is 0, a falling edge on `load_stb` writes `src_addr` into the shadow entry numbered `dst_addr`. No other shadow entry changes. Staging a write never changes `dout`.
- R3: When `load_mode` is 1, a falling edge on `load_stb` writes nothing into the shadow bank. A later commit therefore leaves the routing as it was.
- R4: A falling edge on `cfg_n` copies the full shadow bank into the active bank. The new routing appears at `dout` after the third rising clock edge that follows the fall. It does not appear after the first or second edge.
- R5: During a commit, every output whose code does not change keeps following its input without interruption.
- R6: While `rst_n` is low, every output follows `din[0]`. This takes effect at once, without waiting for a clock edge. After release, outputs stay on `din[0]` until the next commit.
- R7: Reset leaves the shadow bank untouched. The first commit after reset restores the routing that was staged before the reset.
- R8: Only falling strobe edges act, and each edge acts once. Holding `cfg_n` low while new writes are staged does not apply them, and the rising edge of `cfg_n` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the synchronisers and both register banks |
| rst_n | input | 1 | Active-low asynchronous reset; routes all outputs to input 0 |
| load_mode | input | 1 | 0 enables port-by-port staging; 1 blocks shadow writes |
| load_stb | input | 1 | Load strobe; idles low, and its falling edge stages one write |
| cfg_n | input | 1 | Active-low commit strobe; its falling edge copies shadow to active |
| src_addr | input | 4 | Input number to stage |
| dst_addr | input | 4 | Output number whose shadow entry is written |
| din | input | 16 | Data inputs |
| dout | output | 16 | Data outputs |

## Verification
The hardest situation to reach from the ports is a commit strobe held low while new writes land in the shadow bank. A design that copies on level instead of on edge would leak those writes straight into the routing. The stimulus lowers `cfg_n`, stages a write that changes one output's code, and keeps fresh random data on `din` every cycle. It then checks that the output keeps its old source through the rest of the low phase and after the rising edge, and that only the next falling edge applies the write. The bench also commits with a mix of changed and unchanged codes while `din` changes every cycle. This confirms that the untouched outputs never skip a beat on the exact cycle the new routing appears.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Three-stage history of one asynchronous strobe:
    // two synchroniser flops plus one delay flop for edge detection.
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } strb_hist_t;

endpackage

// File: rtl/xpt_edge_sync.sv
module xpt_edge_sync
    import xpt_pkg::*;
#(
    parameter bit IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_i,
    output logic fall_o
);

    strb_hist_t hist_d, hist_q;

    always_comb begin
        hist_d      = hist_q;
        hist_d.meta = strb_i;
        hist_d.sync = hist_q.meta;
        hist_d.prev = hist_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '{meta: IDLE, sync: IDLE, prev: IDLE};
        else        hist_q <= hist_d;
    end

    assign fall_o = hist_q.prev & ~hist_q.sync;

    // R8: one falling edge yields exactly one single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/xpt_shadow_bank.sv
module xpt_shadow_bank #(
    parameter int NUM_OUT = 16,
    parameter int SEL_W   = 4,
    localparam int DST_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [DST_W-1:0]                wr_dst,
    input  logic [SEL_W-1:0]                wr_src,
    output logic [NUM_OUT-1:0][SEL_W-1:0]   shadow_o
);

    logic [NUM_OUT-1:0][SEL_W-1:0] shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (wr_en) shd_d[wr_dst] = wr_src;
    end

    // Deliberately without reset: staged routing survives a reset.
    always_ff @(posedge clk) begin
        shd_q <= shd_d;
    end

    assign shadow_o = shd_q;

    // R2: with no write request the whole bank holds
    a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(shd_q));

    // R2: a write lands in the addressed entry
    a_r2_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> shd_q[$past(wr_dst)] == $past(wr_src));

endmodule

// File: rtl/xpt_active_bank.sv
module xpt_active_bank #(
    parameter int NUM_OUT = 16,
    parameter int SEL_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]   shadow_i,
    output logic [NUM_OUT-1:0][SEL_W-1:0]   active_o
);

    logic [NUM_OUT-1:0][SEL_W-1:0] act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (commit) act_d = shadow_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign active_o = act_q;

    // R4: routing only moves on a commit pulse
    a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_q));

    // R4: a commit takes the whole shadow bank
    a_r4_active_copy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> act_q == $past(shadow_i));

endmodule

// File: rtl/xpt_selector.sv
module xpt_selector #(
    parameter int NUM_IN  = 16,
    parameter int NUM_OUT = 16,
    localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0]               din,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]   sel_i,
    output logic [NUM_OUT-1:0]              dout
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign dout[o] = din[sel_i[o]];
    end

endmodule

// File: rtl/xpt_switch_top.sv
module xpt_switch_top #(
    parameter int NUM_IN  = 16,
    parameter int NUM_OUT = 16,
    localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int DST_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_mode,
    input  logic               load_stb,
    input  logic               cfg_n,
    input  logic [SEL_W-1:0]   src_addr,
    input  logic [DST_W-1:0]   dst_addr,
    input  logic [NUM_IN-1:0]  din,
    output logic [NUM_OUT-1:0] dout
);

    logic load_fall, cfg_fall, stage_wr;
    logic [NUM_OUT-1:0][SEL_W-1:0] shadow, active;

    xpt_edge_sync #(.IDLE(1'b0)) u_load_sync (
        .clk(clk), .rst_n(rst_n), .strb_i(load_stb), .fall_o(load_fall)
    );

    xpt_edge_sync #(.IDLE(1'b1)) u_cfg_sync (
        .clk(clk), .rst_n(rst_n), .strb_i(cfg_n), .fall_o(cfg_fall)
    );

    assign stage_wr = load_fall & ~load_mode;

    xpt_shadow_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(stage_wr),
        .wr_dst(dst_addr), .wr_src(src_addr), .shadow_o(shadow)
    );

    xpt_active_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_active (
        .clk(clk), .rst_n(rst_n), .commit(cfg_fall),
        .shadow_i(shadow), .active_o(active)
    );

    xpt_selector #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_sel (
        .din(din), .sel_i(active), .dout(dout)
    );

    // R3: a blocked load never reaches the shadow bank
    a_r3_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && load_mode) |=> $stable(shadow));

endmodule

// File: tb/xpt_switch_top_tb.sv
`timescale 1ns/1ps
module xpt_switch_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    typedef struct {
        logic [N-1:0] exp;
        logic [N-1:0] mask;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_mode = 1'b0;
    logic         load_stb = 1'b0;
    logic         cfg_n = 1'b1;
    logic [3:0]   src_addr = '0;
    logic [3:0]   dst_addr = '0;
    logic [N-1:0] din = '0;
    logic [N-1:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_sh  [N];
    int m_act [N];
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xpt_switch_top u_dut (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .load_stb(load_stb),
        .cfg_n(cfg_n), .src_addr(src_addr), .dst_addr(dst_addr),
        .din(din), .dout(dout)
    );

    function automatic logic [N-1:0] model_out();
        logic [N-1:0] v;
        for (int o = 0; o < N; o++) v[o] = rst_n ? din[m_act[o]] : din[0];
        return v;
    endfunction

    task automatic push(string r, logic [N-1:0] mask);
        item_t it;
        it.exp = model_out();
        it.mask = mask;
        it.req = r;
        q.push_back(it);
    endtask

    task automatic step_check(string r);
        @(negedge clk);
        din = N'($urandom);
        push(r, '1);
    endtask

    // Monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (((dout ^ it.exp) & it.mask) != '0) begin
                fails++;
                $display("FAIL %s dout=%h expected=%h mask=%h", it.req, dout, it.exp, it.mask);
            end
        end
    end

    task automatic stage(int src, int dst);
        @(negedge clk);
        src_addr = 4'(src);
        dst_addr = 4'(dst);
        load_stb = 1'b1;
        repeat (3) step_check("R2");
        @(negedge clk);
        load_stb = 1'b0;
        repeat (4) step_check("R2");
        if (!load_mode) m_sh[dst] = src;
    endtask

    task automatic cfg_fall_chk(string r);
        logic [N-1:0] same;
        @(negedge clk);
        cfg_n = 1'b0;
        for (int o = 0; o < N; o++) same[o] = (m_sh[o] == m_act[o]);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            din = N'($urandom);
            if (i == 3) m_act = m_sh;
            push(r, '1);
            push("R5", same);
        end
    endtask

    task automatic cfg_rise_chk();
        @(negedge clk);
        cfg_n = 1'b1;
        repeat (4) step_check("R8");
    endtask

    task automatic commit(string r);
        cfg_fall_chk(r);
        repeat (2) step_check(r);
        cfg_rise_chk();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < N; o++) m_act[o] = 0;
        // R6: reset state
        repeat (3) step_check("R6");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) step_check("R6");

        // R1: full table with random fan-out
        for (int o = 0; o < N; o++) stage($urandom_range(N - 1), o);
        commit("R1");

        // R4/R5: random partial updates
        for (int k = 0; k < 15; k++) begin
            int nw = $urandom_range(3, 1);
            for (int w = 0; w < nw; w++) stage($urandom_range(N - 1), $urandom_range(N - 1));
            commit("R4");
        end

        // R1: every output fans out from input 7
        for (int o = 0; o < N; o++) stage(7, o);
        commit("R1");

        // R3: blocked staging
        load_mode = 1'b1;
        stage(9, 3);
        stage(2, 11);
        load_mode = 1'b0;
        commit("R3");

        // R8: write staged while commit strobe is held low is not applied
        cfg_fall_chk("R4");
        stage((m_act[5] + 1) % N, 5);
        repeat (3) step_check("R8");
        cfg_rise_chk();
        commit("R4");

        // R6/R7: reset overrides, then a commit restores the staged routing
        for (int o = 0; o < N; o++) stage((o * 5 + 3) % N, o);
        commit("R1");
        @(negedge clk);
        rst_n = 1'b0;
        din = N'($urandom);
        for (int o = 0; o < N; o++) m_act[o] = 0;
        push("R6", '1);
        repeat (3) step_check("R6");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) step_check("R6");
        commit("R7");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule